// File: doc/BRIEF.md
# Segmented Virtual Address Translator

This block turns a two-part virtual pointer into a 24-bit physical byte address. The upper half of the pointer is a 16-bit selector and the lower half is a 16-bit unsigned offset. Loading a selector starts a descriptor fetch. One selector bit picks one of two tables: the shared global table or the current task's local table. Each table is described by a base/limit register pair that the surrounding logic drives. The block checks that the whole 8-byte entry lies inside the chosen table. It then reads the entry one byte at a time over a byte-wide read port, decodes the entry, and keeps the segment's base and limit in a one-entry cache.

After a successful load, each translation request carries only an offset. The offset is compared against the cached limit and added to the cached base. The result, or a segment-limit fault, appears one cycle later. A failed load leaves the cached segment untouched. A load request that arrives while a fetch is running is dropped.

Top module: `segx_top`

## Requirements
- R1: After synchronous reset the block is idle: `busy`, `mem_rd_en`, `ld_done` and `xl_done` are low.
- R2: The table is chosen by selector bit 2: 0 selects the global table and 1 selects the local table. Bits 15:3 form the entry index, and the first byte read is at table base + index*8. Selector bits 1:0 do not change the address.
- R3: A load reads exactly 8 bytes at consecutive ascending addresses. `busy` stays high from the accept until the cycle of `ld_done`. A load request seen while `busy` is high is ignored and never replayed.
- R4: If index*8+7 exceeds the chosen table's limit register, the load ends with `ld_fault`. No memory read is issued and the cached segment is unchanged. An entry whose last byte equals the limit is accepted.
- R5: Entry layout is little-endian: bytes 0-1 hold the 16-bit limit, bytes 2-4 the 24-bit base, byte 5 the access byte, and bytes 6-7 are ignored. Access bit 4 set marks a memory segment. A data load (`ld_sys`=0) of such an entry caches base and limit and drives `seg_sys`=0.
- R6: A system load (`ld_sys`=1) of an entry with access bit 4 clear succeeds only for access bits 3:0 in 1..7. It then caches the entry with `seg_sys`=1 and `seg_type` = those bits. Type codes 0, 8 and 9..15 fault.
- R7: A kind mismatch faults and leaves the cache unchanged. This covers a data load of an entry with bit 4 clear and a system load of an entry with bit 4 set.
- R8: A translation request with offset <= cached limit gives `xl_done` one cycle later, with `xl_fault`=0 and `xl_pa` = (base + offset) mod 2^24.
- R9: A translation request with offset > cached limit gives `xl_done` with `xl_fault`=1 and `xl_pa`=0.
- R10: Before the first successful load, every translation request faults.
- R11: The table base/limit registers are sampled when a load begins, so a changed local table register applies to the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gtab_base | input | 24 | Global table physical base |
| gtab_lim | input | 16 | Global table limit (offset of its last byte) |
| ltab_base | input | 24 | Local table physical base |
| ltab_lim | input | 16 | Local table limit (offset of its last byte) |
| ld_valid | input | 1 | Selector load request |
| ld_sel | input | 16 | Selector to load |
| ld_sys | input | 1 | 1 = load as system descriptor, 0 = as data segment |
| busy | output | 1 | Descriptor fetch in progress |
| mem_rd_en | output | 1 | Byte read strobe |
| mem_addr | output | 24 | Byte read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the strobe |
| ld_done | output | 1 | One-cycle pulse ending a load |
| ld_fault | output | 1 | Load failed (with `ld_done`) |
| seg_sys | output | 1 | Cached entry is a system descriptor |
| seg_type | output | 4 | Cached access type bits |
| xl_req | input | 1 | Translation request |
| xl_off | input | 16 | Offset to translate |
| xl_done | output | 1 | Translation result valid |
| xl_fault | output | 1 | Segment-limit fault |
| xl_pa | output | 24 | Physical address |

## Verification
The bench probes the table bound at the exact boundary: index 7 in a 64-byte table passes and index 8 fails. An off-by-one compare would either reject the last entry or fetch past the table. It sets the requestor bits to nonzero values and changes the local base between loads, which would expose a wrong address formed from the selector or a table register latched at the wrong time. It also loads an entry whose base plus offset wraps past 2^24, tests the offset equal to the limit and one above it, and covers every class of system type code. A decoder with a wrong type range or limit compare would fault on good entries or accept bad ones. Finally, it issues a second load during a fetch and checks that the cache and read count show only the first load.

// File: rtl/segx_pkg.sv
package segx_pkg;
    localparam int PA_W      = 24;
    localparam int OFF_W     = 16;
    localparam int SEL_W     = 16;
    localparam int IDX_W     = 13;
    localparam int TLIM_W    = 16;
    localparam int ENT_BYTES = 8;
    localparam int ENT_SH    = $clog2(ENT_BYTES);
    localparam int CNT_W     = $clog2(ENT_BYTES);
    localparam int TI_BIT    = 2;
    localparam int KIND_BIT  = 4;
    localparam int TYPE_W    = 4;

    typedef enum logic [2:0] {
        FS_IDLE, FS_CALC, FS_READ, FS_DRAIN, FS_DECODE, FS_DONE
    } fetch_st_e;

    typedef struct packed {
        logic [7:0]        access;
        logic [PA_W-1:0]   base;
        logic [OFF_W-1:0]  limit;
    } desc_t;

    typedef struct packed {
        logic              valid;
        logic              sys;
        logic [TYPE_W-1:0] typ;
        logic [PA_W-1:0]   base;
        logic [OFF_W-1:0]  limit;
    } seg_cache_t;

    function automatic logic sys_type_ok(input logic [TYPE_W-1:0] t);
        return (t >= 4'd1) && (t <= 4'd7);
    endfunction
endpackage

// File: rtl/segx_table_sel.sv
module segx_table_sel
    import segx_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  logic [PA_W-1:0]   gbase,
    input  logic [TLIM_W-1:0] glim,
    input  logic [PA_W-1:0]   lbase,
    input  logic [TLIM_W-1:0] llim,
    output logic [PA_W-1:0]   entry_addr,
    output logic              bound_fault
);
    logic [IDX_W-1:0]  idx;
    logic              use_local;
    logic [TLIM_W-1:0] last_byte;
    logic [PA_W-1:0]   tbase;
    logic [TLIM_W-1:0] tlim;

    always_comb begin
        idx        = sel[SEL_W-1:TI_BIT+1];
        use_local  = sel[TI_BIT];
        tbase      = use_local ? lbase : gbase;
        tlim       = use_local ? llim  : glim;
        last_byte  = {idx, {ENT_SH{1'b1}}};
        entry_addr = tbase + PA_W'({idx, {ENT_SH{1'b0}}});
        bound_fault = last_byte > tlim;
    end
endmodule

// File: rtl/segx_fetch.sv
module segx_fetch
    import segx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic [SEL_W-1:0]  ld_sel,
    input  logic              ld_sys,
    input  logic [PA_W-1:0]   gbase,
    input  logic [TLIM_W-1:0] glim,
    input  logic [PA_W-1:0]   lbase,
    input  logic [TLIM_W-1:0] llim,
    output logic              busy,
    output logic              mem_rd_en,
    output logic [PA_W-1:0]   mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic              fin_vld,
    output logic              fin_bound,
    output logic              fin_sys,
    output desc_t             fin_desc
);
    fetch_st_e         st;
    logic [SEL_W-1:0]  sel_q;
    logic              sys_q;
    logic [PA_W-1:0]   entry_q;
    logic [CNT_W-1:0]  cnt;
    logic              cap_en;
    logic [CNT_W-1:0]  cap_idx;
    logic [7:0]        byte_q [ENT_BYTES];
    logic [PA_W-1:0]   entry_addr;
    logic              bound_fault;

    segx_table_sel u_tsel (
        .sel(sel_q), .gbase(gbase), .glim(glim), .lbase(lbase), .llim(llim),
        .entry_addr(entry_addr), .bound_fault(bound_fault)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= FS_IDLE;
            sel_q   <= '0;
            sys_q   <= 1'b0;
            entry_q <= '0;
            cnt     <= '0;
        end else begin
            unique case (st)
                FS_IDLE: if (ld_valid) begin
                    sel_q <= ld_sel;
                    sys_q <= ld_sys;
                    st    <= FS_CALC;
                end
                FS_CALC: begin
                    entry_q <= entry_addr;
                    cnt     <= '0;
                    st      <= bound_fault ? FS_DONE : FS_READ;
                end
                FS_READ: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(ENT_BYTES-1)) st <= FS_DRAIN;
                end
                FS_DRAIN:  st <= FS_DECODE;
                FS_DECODE: st <= FS_DONE;
                FS_DONE:   st <= FS_IDLE;
                default:   st <= FS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_en  <= 1'b0;
            cap_idx <= '0;
        end else begin
            cap_en  <= (st == FS_READ);
            cap_idx <= cnt;
        end
    end

    for (genvar b = 0; b < ENT_BYTES; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                byte_q[b] <= '0;
            else if (cap_en && cap_idx == CNT_W'(b))
                byte_q[b] <= mem_rdata;
        end
    end

    always_comb begin
        busy      = (st != FS_IDLE);
        mem_rd_en = (st == FS_READ);
        mem_addr  = entry_q + PA_W'(cnt);
        fin_bound = (st == FS_CALC);
        fin_vld   = (st == FS_CALC && bound_fault) || (st == FS_DECODE);
        fin_sys   = sys_q;
        fin_desc.limit  = {byte_q[1], byte_q[0]};
        fin_desc.base   = {byte_q[4], byte_q[3], byte_q[2]};
        fin_desc.access = byte_q[5];
    end
endmodule

// File: rtl/segx_cache.sv
module segx_cache
    import segx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fin_vld,
    input  logic       fin_bound,
    input  logic       fin_sys,
    input  desc_t      fin_desc,
    output logic       ld_done,
    output logic       ld_fault,
    output seg_cache_t cache
);
    logic              mem_kind;
    logic [TYPE_W-1:0] typ;
    logic              accept;

    always_comb begin
        mem_kind = fin_desc.access[KIND_BIT];
        typ      = fin_desc.access[TYPE_W-1:0];
        if (fin_bound)
            accept = 1'b0;
        else if (fin_sys)
            accept = !mem_kind && sys_type_ok(typ);
        else
            accept = mem_kind;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_done  <= 1'b0;
            ld_fault <= 1'b0;
            cache    <= '0;
        end else begin
            ld_done  <= fin_vld;
            ld_fault <= fin_vld && !accept;
            if (fin_vld && accept) begin
                cache.valid <= 1'b1;
                cache.sys   <= !mem_kind;
                cache.typ   <= typ;
                cache.base  <= fin_desc.base;
                cache.limit <= fin_desc.limit;
            end
        end
    end
endmodule

// File: rtl/segx_path.sv
module segx_path
    import segx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  seg_cache_t       cache,
    input  logic             xl_req,
    input  logic [OFF_W-1:0] xl_off,
    output logic             xl_done,
    output logic             xl_fault,
    output logic [PA_W-1:0]  xl_pa
);
    logic over;

    always_comb over = !cache.valid || (xl_off > cache.limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            xl_done  <= 1'b0;
            xl_fault <= 1'b0;
            xl_pa    <= '0;
        end else begin
            xl_done <= xl_req;
            if (xl_req) begin
                xl_fault <= over;
                xl_pa    <= over ? '0 : cache.base + PA_W'(xl_off);
            end
        end
    end
endmodule

// File: rtl/segx_top.sv
module segx_top
    import segx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PA_W-1:0]   gtab_base,
    input  logic [TLIM_W-1:0] gtab_lim,
    input  logic [PA_W-1:0]   ltab_base,
    input  logic [TLIM_W-1:0] ltab_lim,
    input  logic              ld_valid,
    input  logic [SEL_W-1:0]  ld_sel,
    input  logic              ld_sys,
    output logic              busy,
    output logic              mem_rd_en,
    output logic [PA_W-1:0]   mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic              ld_done,
    output logic              ld_fault,
    output logic              seg_sys,
    output logic [TYPE_W-1:0] seg_type,
    input  logic              xl_req,
    input  logic [OFF_W-1:0]  xl_off,
    output logic              xl_done,
    output logic              xl_fault,
    output logic [PA_W-1:0]   xl_pa
);
    logic       fin_vld, fin_bound, fin_sys;
    desc_t      fin_desc;
    seg_cache_t cache;

    segx_fetch u_fetch (
        .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_sel(ld_sel), .ld_sys(ld_sys),
        .gbase(gtab_base), .glim(gtab_lim), .lbase(ltab_base), .llim(ltab_lim),
        .busy(busy), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .fin_vld(fin_vld), .fin_bound(fin_bound), .fin_sys(fin_sys), .fin_desc(fin_desc)
    );

    segx_cache u_cache (
        .clk(clk), .rst(rst), .fin_vld(fin_vld), .fin_bound(fin_bound),
        .fin_sys(fin_sys), .fin_desc(fin_desc),
        .ld_done(ld_done), .ld_fault(ld_fault), .cache(cache)
    );

    segx_path u_path (
        .clk(clk), .rst(rst), .cache(cache), .xl_req(xl_req), .xl_off(xl_off),
        .xl_done(xl_done), .xl_fault(xl_fault), .xl_pa(xl_pa)
    );

    always_comb begin
        seg_sys  = cache.sys;
        seg_type = cache.typ;
    end
endmodule

// File: rtl/segx_chk.sv
module segx_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        mem_rd_en,
    input logic [23:0] mem_addr,
    input logic        ld_done,
    input logic        ld_fault,
    input logic        seg_sys,
    input logic [3:0]  seg_type,
    input logic        xl_req,
    input logic        xl_done
);
    assert_read_in_fetch_R3: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> busy);

    assert_read_ascending_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && $past(mem_rd_en)) |-> mem_addr == $past(mem_addr) + 24'd1);

    assert_done_while_busy_R3: assert property (@(posedge clk) disable iff (rst)
        ld_done |-> busy);

    assert_fault_with_done_R4: assert property (@(posedge clk) disable iff (rst)
        ld_fault |-> ld_done);

    assert_fault_keeps_cache_R7: assert property (@(posedge clk) disable iff (rst)
        ld_fault |-> ($stable(seg_sys) && $stable(seg_type)));

    assert_cache_moves_on_load_R5: assert property (@(posedge clk) disable iff (rst)
        !ld_done |-> ($stable(seg_sys) && $stable(seg_type)));

    assert_xlate_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        xl_req |=> xl_done);
endmodule

bind segx_top segx_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .ld_done(ld_done), .ld_fault(ld_fault), .seg_sys(seg_sys), .seg_type(seg_type),
    .xl_req(xl_req), .xl_done(xl_done)
);

// File: tb/segx_top_bench.sv
`timescale 1ns/1ps
module segx_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] gtab_base = 24'h000100;
    logic [15:0] gtab_lim  = 16'h003F;
    logic [23:0] ltab_base = 24'h000800;
    logic [15:0] ltab_lim  = 16'h001F;
    logic        ld_valid = 1'b0;
    logic [15:0] ld_sel = '0;
    logic        ld_sys = 1'b0;
    logic        busy, mem_rd_en, ld_done, ld_fault, seg_sys;
    logic [23:0] mem_addr, xl_pa;
    logic [7:0]  mem_rdata;
    logic [3:0]  seg_type;
    logic        xl_req = 1'b0;
    logic [15:0] xl_off = '0;
    logic        xl_done, xl_fault;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [7:0]  mem [4096];
    int          rd_cnt;
    logic [23:0] rd_first, rd_last;
    bit          rd_seq_bad;

    always #10 clk = ~clk;

    segx_top u_segx_top (
        .clk(clk), .rst(rst), .gtab_base(gtab_base), .gtab_lim(gtab_lim),
        .ltab_base(ltab_base), .ltab_lim(ltab_lim), .ld_valid(ld_valid),
        .ld_sel(ld_sel), .ld_sys(ld_sys), .busy(busy), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .ld_done(ld_done),
        .ld_fault(ld_fault), .seg_sys(seg_sys), .seg_type(seg_type),
        .xl_req(xl_req), .xl_off(xl_off), .xl_done(xl_done),
        .xl_fault(xl_fault), .xl_pa(xl_pa)
    );

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= mem[mem_addr[11:0]];
            if (rd_cnt == 0) rd_first = mem_addr;
            else if (mem_addr != rd_last + 24'd1) rd_seq_bad = 1;
            rd_last = mem_addr;
            rd_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_desc(input int addr, input logic [15:0] lim, input logic [23:0] base, input logic [7:0] acc);
        mem[addr]   = lim[7:0];
        mem[addr+1] = lim[15:8];
        mem[addr+2] = base[7:0];
        mem[addr+3] = base[15:8];
        mem[addr+4] = base[23:16];
        mem[addr+5] = acc;
        mem[addr+6] = 8'hA5;
        mem[addr+7] = 8'h5A;
    endtask

    task automatic do_load(input logic [15:0] sel, input logic sys, output bit got, output bit f);
        rd_cnt = 0; rd_seq_bad = 0; got = 0; f = 0;
        @(negedge clk); ld_valid = 1; ld_sel = sel; ld_sys = sys;
        @(negedge clk); ld_valid = 0;
        for (int i = 0; i < 40; i++) begin
            if (ld_done) begin got = 1; f = ld_fault; break; end
            @(negedge clk);
        end
        while (busy) @(negedge clk);
    endtask

    task automatic do_xl(input logic [15:0] off, output bit done, output bit f, output logic [23:0] pa);
        @(negedge clk); xl_req = 1; xl_off = off;
        @(negedge clk); xl_req = 0;
        done = xl_done; f = xl_fault; pa = xl_pa;
    endtask

    task automatic t_reset();
        bit d, f; logic [23:0] pa;
        check(!busy && !mem_rd_en && !ld_done && !xl_done, "R1", {busy, mem_rd_en, ld_done, xl_done}, 0);
        do_xl(16'h0000, d, f, pa);
        check(d && f, "R10", {d, f}, 2'b11);
    endtask

    task automatic t_global_data();
        bit g, f, d; logic [23:0] pa;
        put_desc(24'h100 + 16, 16'h0FFF, 24'h123400, 8'h92);
        do_load({13'd2, 1'b0, 2'b11}, 1'b0, g, f);
        check(g && !f, "R5", {g, f}, 2'b10);
        check(rd_first == 24'h000110, "R2", rd_first, 24'h000110);
        check(rd_cnt == 8 && !rd_seq_bad, "R3", rd_cnt, 8);
        check(seg_sys == 1'b0, "R5", seg_sys, 0);
        do_xl(16'h0010, d, f, pa);
        check(d && !f && pa == 24'h123410, "R8", pa, 24'h123410);
        do_xl(16'h0FFF, d, f, pa);
        check(d && !f && pa == 24'h1243FF, "R8", pa, 24'h1243FF);
        do_xl(16'h1000, d, f, pa);
        check(d && f && pa == 24'h0, "R9", {f, pa}, {1'b1, 24'h0});
    endtask

    task automatic t_local();
        bit g, f, d; logic [23:0] pa;
        put_desc(24'h808, 16'hFFFF, 24'hFFFF00, 8'h90);
        do_load({13'd1, 1'b1, 2'b00}, 1'b0, g, f);
        check(g && !f && rd_first == 24'h000808, "R2", rd_first, 24'h000808);
        do_xl(16'h0100, d, f, pa);
        check(d && !f && pa == 24'h000000, "R8", pa, 24'h0);
        ltab_base = 24'h000A00;
        put_desc(24'hA08, 16'h0010, 24'h050000, 8'h93);
        do_load({13'd1, 1'b1, 2'b10}, 1'b0, g, f);
        check(g && !f && rd_first == 24'h000A08, "R11", rd_first, 24'h000A08);
        do_xl(16'h0005, d, f, pa);
        check(d && !f && pa == 24'h050005, "R11", pa, 24'h050005);
    endtask

    task automatic t_bound();
        bit g, f, d; logic [23:0] pa;
        do_load({13'd8, 1'b0, 2'b00}, 1'b0, g, f);
        check(g && f, "R4", {g, f}, 2'b11);
        check(rd_cnt == 0, "R4", rd_cnt, 0);
        do_xl(16'h0005, d, f, pa);
        check(d && !f && pa == 24'h050005, "R4", pa, 24'h050005);
        put_desc(24'h100 + 56, 16'h0020, 24'h000300, 8'h90);
        do_load({13'd7, 1'b0, 2'b01}, 1'b0, g, f);
        check(g && !f && rd_cnt == 8, "R4", {f, rd_cnt[7:0]}, {1'b0, 8'd8});
        do_xl(16'h0020, d, f, pa);
        check(d && !f && pa == 24'h000320, "R8", pa, 24'h000320);
    endtask

    task automatic t_sys();
        bit g, f;
        put_desc(24'h100 + 24, 16'h0100, 24'h000400, 8'h82);
        put_desc(24'h100 + 32, 16'h0100, 24'h000400, 8'h88);
        put_desc(24'h100 + 40, 16'h0100, 24'h000400, 8'h80);
        put_desc(24'h100 + 48, 16'h0100, 24'h000400, 8'h8C);
        do_load({13'd3, 1'b0, 2'b00}, 1'b1, g, f);
        check(g && !f && seg_sys && seg_type == 4'd2, "R6", {f, seg_sys, seg_type}, {2'b01, 4'd2});
        do_load({13'd4, 1'b0, 2'b00}, 1'b1, g, f);
        check(g && f && seg_type == 4'd2, "R6", {f, seg_type}, {1'b1, 4'd2});
        do_load({13'd5, 1'b0, 2'b00}, 1'b1, g, f);
        check(g && f && seg_type == 4'd2, "R6", {f, seg_type}, {1'b1, 4'd2});
        do_load({13'd6, 1'b0, 2'b00}, 1'b1, g, f);
        check(g && f && seg_type == 4'd2, "R6", {f, seg_type}, {1'b1, 4'd2});
    endtask

    task automatic t_mismatch();
        bit g, f;
        do_load({13'd3, 1'b0, 2'b00}, 1'b0, g, f);
        check(g && f && seg_sys && seg_type == 4'd2, "R7", {f, seg_sys, seg_type}, {2'b11, 4'd2});
        do_load({13'd2, 1'b0, 2'b00}, 1'b1, g, f);
        check(g && f && seg_sys, "R7", {f, seg_sys}, 2'b11);
    endtask

    task automatic t_busy_ignore();
        bit got;
        rd_cnt = 0; rd_seq_bad = 0; got = 0;
        @(negedge clk); ld_valid = 1; ld_sel = {13'd2, 1'b0, 2'b00}; ld_sys = 0;
        @(negedge clk); ld_valid = 0;
        check(busy, "R3", busy, 1);
        @(negedge clk); ld_valid = 1; ld_sel = {13'd3, 1'b0, 2'b00}; ld_sys = 1;
        @(negedge clk); ld_valid = 0;
        for (int i = 0; i < 40; i++) begin
            if (ld_done) begin got = 1; break; end
            @(negedge clk);
        end
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
        check(got && !busy && rd_cnt == 8 && !rd_seq_bad, "R3", rd_cnt, 8);
        check(seg_sys == 1'b0, "R3", seg_sys, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_global_data();
        t_local();
        t_bound();
        t_sys();
        t_mismatch();
        t_busy_ignore();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule